// File: doc/BRIEF.md
# Default-Transition Multi-String Matching Engine

This block walks a compressed multi-pattern automaton through a packet, one byte per clock. Each state keeps only a handful of explicit transitions. Any byte that finds none of them falls back to a shared per-byte default word. That word names a depth-1 target, four depth-2 targets qualified by the previous byte, and one depth-3 target qualified by the previous two bytes. The automaton has no failure links, so the engine never stalls and never spends a cycle on a wasted transition.

Each accepted byte arrives with its default word, which an outside table has already looked up by the byte value. The engine also registers the record of the current state, which state memory returns for the address the engine last requested. In the next cycle it picks the next state and drives that state's address and type as a read request. Default targets carry no address. Each default slot maps to a fixed location in state memory, computed from parameter bases and the byte value. One cycle after a state is reached, the engine raises a match flag with the match-list location, if that state's record flags a match.

Top module: `dtm_stepper`

Encodings used by the requirements (default parameters):
- State record: bits [3:0] hold the count n of valid stored transitions. Bits [15:4] hold the match field: bit 15 is the match flag and bits [14:4] are the list location. Stored transition i sits at bits [16+24i +: 24], with the trigger byte in [7:0], the target address in [19:8] and the target type in [23:20].
- Default word: bit 0 says a depth-1 target exists. Depth-2 slot k's predecessor byte sits at [1+8k +: 8]. The depth-3 pair sits at [33 +: 16]: the upper byte is compared with the byte two back and the lower byte with the previous byte.
- Fixed target locations:
  - Depth-1: BASE1 + b.
  - Depth-2 slot k: BASE2 + 4b + k.
  - Depth-3: BASE3 + b.
  - Start state: START_ADDR with type START_TYPE.
  - Every default target has type DFLT_TYPE.

## Requirements
- R1: Every byte accepted with in_valid produces req_valid in the next cycle, carrying that byte's next state. Back-to-back bytes are all accepted with no stall.
- R2: A stored transition whose index is below the record count n and whose trigger equals the byte wins over every default. The request then carries its target address and type. Entries at index n or above are ignored.
- R3: When several valid stored transitions share the byte as trigger, the one with the lowest index is taken.
- R4: With no stored hit, at least two previous bytes in the packet, and the depth-3 pair equal to {byte two back, previous byte}, the request is BASE3 + b with type DFLT_TYPE.
- R5: Otherwise, with at least one previous byte in the packet, the lowest slot k whose predecessor byte equals the previous byte gives BASE2 + 4b + k with type DFLT_TYPE.
- R6: Otherwise, if bit 0 of the default word is set, the request is BASE1 + b with type DFLT_TYPE.
- R7: Otherwise the request is START_ADDR with type START_TYPE.
- R8: For a byte flagged in_first, the fetched state record is ignored. The request is then the depth-1 target or the start state.
- R9: Byte history restarts at every in_first byte, so no default comparison uses a byte from an earlier packet.
- R10: One cycle after a request, match_hit is high exactly when the requested state's record has bit 15 set, and match_addr gives bits [14:4].
- R11: In a cycle with no request, req_valid is low and req_addr and req_type hold the current state. After reset the current state is the start state and match_hit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet byte is presented this cycle |
| in_first | input | 1 | The presented byte starts a packet |
| in_byte | input | BYTE_W | Packet byte |
| in_dflt | input | DW_W | Default word looked up by in_byte |
| st_rec | input | REC_W | Record of the state at req_addr, from state memory |
| req_valid | output | 1 | A new next state is requested this cycle |
| req_addr | output | ADDR_W | State memory address of the next or current state |
| req_type | output | TYPE_W | Type of that state |
| match_hit | output | 1 | The state just reached flags a match |
| match_addr | output | MF_W-1 | Match-list location of that state |

## Verification
The bench uses the default parameters: 13 stored transitions per state, four depth-2 slots, 12-bit addresses and bases 1, 257 and 1281. With these values the last stored slot (index 12) can be reached, and a trigger can sit past the record count. Duplicate triggers and a depth-2 word with two slots carrying the same predecessor can both be built. A depth-3 pair can overlap a depth-2 slot, so each priority step is exercised against the one below it. Packets that end and restart with crafted byte orders show that history and the fetched record are dropped at packet start. Idle gaps between bytes show that the current state is held.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  // which rule produced the next state, in rising priority
  typedef enum logic [2:0] {
    SRC_START  = 3'd0,
    SRC_D1     = 3'd1,
    SRC_D2     = 3'd2,
    SRC_D3     = 3'd3,
    SRC_STORED = 3'd4
  } src_e;

  // fixed location of a depth-1 default target
  function automatic int unsigned loc_d1(input int unsigned base, input int unsigned b);
    return base + b;
  endfunction

  // fixed location of depth-2 slot k for byte b
  function automatic int unsigned loc_d2(input int unsigned base, input int unsigned b,
                                         input int unsigned k, input int unsigned nslot);
    return base + nslot * b + k;
  endfunction

  // fixed location of a depth-3 default target
  function automatic int unsigned loc_d3(input int unsigned base, input int unsigned b);
    return base + b;
  endfunction

endpackage

// File: rtl/dtm_hist.sv
// Input stage: current byte, packet-start flag and the two bytes before it.
module dtm_hist #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              valid_q,
  output logic              first_q,
  output logic [BYTE_W-1:0] byte_q,
  output logic [BYTE_W-1:0] p1_q,
  output logic [BYTE_W-1:0] p2_q,
  output logic [1:0]        hcnt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      first_q <= 1'b0;
      byte_q  <= '0;
      p1_q    <= '0;
      p2_q    <= '0;
      hcnt_q  <= 2'd0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        byte_q  <= in_byte;
        first_q <= in_first;
        if (in_first) begin
          hcnt_q <= 2'd0;
        end else begin
          p1_q <= byte_q;
          p2_q <= p1_q;
          if (hcnt_q != 2'd2) hcnt_q <= hcnt_q + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/dtm_xsearch.sv
// Compares the byte with every valid stored transition; lowest index wins.
module dtm_xsearch #(
  parameter int MAXT   = 13,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 12,
  parameter int TYPE_W = 4,
  localparam int CNT_W = $clog2(MAXT + 1),
  localparam int TR_W  = BYTE_W + ADDR_W + TYPE_W
) (
  input  logic [CNT_W-1:0]     cnt,
  input  logic [MAXT*TR_W-1:0] trans,
  input  logic [BYTE_W-1:0]    byte_i,
  output logic                 hit,
  output logic [ADDR_W-1:0]    hit_addr,
  output logic [TYPE_W-1:0]    hit_type
);

  logic [MAXT-1:0] cand;

  for (genvar i = 0; i < MAXT; i++) begin : g_ent
    logic [TR_W-1:0] ent;
    assign ent     = trans[i*TR_W +: TR_W];
    assign cand[i] = (CNT_W'(i) < cnt) && (ent[BYTE_W-1:0] == byte_i);
  end

  always_comb begin
    hit      = |cand;
    hit_addr = '0;
    hit_type = '0;
    for (int i = MAXT - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit_addr = trans[i*TR_W + BYTE_W +: ADDR_W];
        hit_type = trans[i*TR_W + BYTE_W + ADDR_W +: TYPE_W];
      end
    end
  end

endmodule

// File: rtl/dtm_dflt.sv
// Picks among the depth-3, depth-2, depth-1 defaults and the start state.
module dtm_dflt #(
  parameter int          BYTE_W     = 8,
  parameter int          ADDR_W     = 12,
  parameter int          TYPE_W     = 4,
  parameter int          NSLOT      = 4,
  parameter int unsigned BASE1      = 1,
  parameter int unsigned BASE2      = 257,
  parameter int unsigned BASE3      = 1281,
  parameter int unsigned START_ADDR = 0,
  parameter int unsigned START_TYPE = 0,
  parameter int unsigned DFLT_TYPE  = 1,
  localparam int DW_W  = 1 + NSLOT * BYTE_W + 2 * BYTE_W,
  localparam int PAIR0 = 1 + NSLOT * BYTE_W
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [DW_W-1:0]   word,
  input  logic [BYTE_W-1:0] p1,
  input  logic [BYTE_W-1:0] p2,
  input  logic [1:0]        hcnt,
  output dtm_pkg::src_e     src,
  output logic [ADDR_W-1:0] d_addr,
  output logic [TYPE_W-1:0] d_type
);
  import dtm_pkg::*;

  logic [NSLOT-1:0] slot_hit;
  logic             d3_hit;
  logic             d1_hit;
  int unsigned      slot_k;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign slot_hit[k] = (hcnt != 2'd0) && (word[1 + k*BYTE_W +: BYTE_W] == p1);
  end

  assign d3_hit = (hcnt == 2'd2) && (word[PAIR0 +: 2*BYTE_W] == {p2, p1});
  assign d1_hit = word[0];

  always_comb begin
    slot_k = 0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (slot_hit[k]) slot_k = k;
    end
  end

  always_comb begin
    if (d3_hit) begin
      src    = SRC_D3;
      d_addr = ADDR_W'(loc_d3(BASE3, 32'(byte_i)));
      d_type = TYPE_W'(DFLT_TYPE);
    end else if (|slot_hit) begin
      src    = SRC_D2;
      d_addr = ADDR_W'(loc_d2(BASE2, 32'(byte_i), slot_k, NSLOT));
      d_type = TYPE_W'(DFLT_TYPE);
    end else if (d1_hit) begin
      src    = SRC_D1;
      d_addr = ADDR_W'(loc_d1(BASE1, 32'(byte_i)));
      d_type = TYPE_W'(DFLT_TYPE);
    end else begin
      src    = SRC_START;
      d_addr = ADDR_W'(START_ADDR);
      d_type = TYPE_W'(START_TYPE);
    end
  end

endmodule

// File: rtl/dtm_stepper.sv
module dtm_stepper #(
  parameter int          BYTE_W     = 8,
  parameter int          ADDR_W     = 12,
  parameter int          TYPE_W     = 4,
  parameter int          MAXT       = 13,
  parameter int          NSLOT      = 4,
  parameter int          MF_W       = 12,
  parameter int unsigned BASE1      = 1,
  parameter int unsigned BASE2      = 257,
  parameter int unsigned BASE3      = 1281,
  parameter int unsigned START_ADDR = 0,
  parameter int unsigned START_TYPE = 0,
  parameter int unsigned DFLT_TYPE  = 1,
  localparam int CNT_W = $clog2(MAXT + 1),
  localparam int TR_W  = BYTE_W + ADDR_W + TYPE_W,
  localparam int REC_W = CNT_W + MF_W + MAXT * TR_W,
  localparam int DW_W  = 1 + NSLOT * BYTE_W + 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [DW_W-1:0]   in_dflt,
  input  logic [REC_W-1:0]  st_rec,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [TYPE_W-1:0] req_type,
  output logic              match_hit,
  output logic [MF_W-2:0]   match_addr
);
  import dtm_pkg::*;

  // input stage
  logic              valid_q, first_q;
  logic [BYTE_W-1:0] byte_q, p1_q, p2_q;
  logic [1:0]        hcnt_q;

  dtm_hist #(.BYTE_W(BYTE_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_byte(in_byte), .valid_q(valid_q), .first_q(first_q), .byte_q(byte_q),
    .p1_q(p1_q), .p2_q(p2_q), .hcnt_q(hcnt_q)
  );

  // registered record, default word, current state and its type
  logic [REC_W-1:0]  rec_q;
  logic [DW_W-1:0]   dw_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [TYPE_W-1:0] cur_type_q;
  logic              arrive_q;

  // decision wires, named for the checks below
  logic              use_rec;
  logic              x_hit;
  logic [ADDR_W-1:0] x_addr;
  logic [TYPE_W-1:0] x_type;
  src_e              d_src;
  logic [ADDR_W-1:0] d_addr;
  logic [TYPE_W-1:0] d_type;
  src_e              nxt_src;
  logic [ADDR_W-1:0] nxt_addr;
  logic [TYPE_W-1:0] nxt_type;

  dtm_xsearch #(
    .MAXT(MAXT), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)
  ) u_xs (
    .cnt(rec_q[CNT_W-1:0]),
    .trans(rec_q[CNT_W + MF_W +: MAXT*TR_W]),
    .byte_i(byte_q),
    .hit(x_hit), .hit_addr(x_addr), .hit_type(x_type)
  );

  dtm_dflt #(
    .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .NSLOT(NSLOT),
    .BASE1(BASE1), .BASE2(BASE2), .BASE3(BASE3),
    .START_ADDR(START_ADDR), .START_TYPE(START_TYPE), .DFLT_TYPE(DFLT_TYPE)
  ) u_df (
    .byte_i(byte_q), .word(dw_q), .p1(p1_q), .p2(p2_q), .hcnt(hcnt_q),
    .src(d_src), .d_addr(d_addr), .d_type(d_type)
  );

  // the fetched record is meaningful only inside a packet
  assign use_rec = valid_q && !first_q;

  always_comb begin
    if (use_rec && x_hit) begin
      nxt_src  = SRC_STORED;
      nxt_addr = x_addr;
      nxt_type = x_type;
    end else begin
      nxt_src  = d_src;
      nxt_addr = d_addr;
      nxt_type = d_type;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_q      <= '0;
      dw_q       <= '0;
      cur_addr_q <= ADDR_W'(START_ADDR);
      cur_type_q <= TYPE_W'(START_TYPE);
      arrive_q   <= 1'b0;
    end else begin
      rec_q    <= st_rec;
      arrive_q <= valid_q;
      if (in_valid) dw_q <= in_dflt;
      if (valid_q) begin
        cur_addr_q <= nxt_addr;
        cur_type_q <= nxt_type;
      end
    end
  end

  assign req_valid  = valid_q;
  assign req_addr   = valid_q ? nxt_addr : cur_addr_q;
  assign req_type   = valid_q ? nxt_type : cur_type_q;
  assign match_hit  = arrive_q && rec_q[CNT_W + MF_W - 1];
  assign match_addr = rec_q[CNT_W +: MF_W-1];

  // R1
  one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> req_valid);

  // R1
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !req_valid);

  // R8
  first_byte_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && first_q) |-> (nxt_src == SRC_D1 || nxt_src == SRC_START));

  // R9
  d3_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && nxt_src == SRC_D3) |-> (hcnt_q == 2'd2));

  // R6
  d1_exists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && nxt_src == SRC_D1) |-> dw_q[0]);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !$past(req_valid)) |-> ($stable(req_addr) && $stable(req_type)));

  // R10
  match_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> $past(req_valid));

endmodule

// File: tb/sim_dtm_stepper.sv
module sim_dtm_stepper;
  localparam int CLK_PER = 10;
  localparam int REC_W   = 328;
  localparam int DW_W    = 49;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_first = 1'b0;
  logic [7:0]       in_byte = 8'h00;
  logic [DW_W-1:0]  in_dflt;
  logic [REC_W-1:0] st_rec;
  logic             req_valid;
  logic [11:0]      req_addr;
  logic [3:0]       req_type;
  logic             match_hit;
  logic [10:0]      match_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  dtm_stepper u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_byte(in_byte), .in_dflt(in_dflt), .st_rec(st_rec),
    .req_valid(req_valid), .req_addr(req_addr), .req_type(req_type),
    .match_hit(match_hit), .match_addr(match_addr)
  );

  // ---- bench data: state records and default words ----
  function automatic logic [REC_W-1:0] put_tr(input logic [REC_W-1:0] r, input int i,
                                              input logic [7:0] trg, input logic [11:0] a,
                                              input logic [3:0] t);
    logic [REC_W-1:0] o;
    o = r;
    o[16 + 24*i +: 24] = {t, a, trg};
    return o;
  endfunction

  function automatic logic [REC_W-1:0] rec_of(input logic [11:0] a);
    logic [REC_W-1:0] r;
    r = '0;
    case (a)
      12'd98: begin
        r[3:0] = 4'd3;
        r = put_tr(r, 0, 8'h78, 12'h700, 4'd5);
        r = put_tr(r, 1, 8'h78, 12'h701, 4'd6);
        r = put_tr(r, 2, 8'h71, 12'h702, 4'd7);
        r = put_tr(r, 3, 8'h63, 12'h703, 4'd8);
      end
      12'h700: begin
        r[3:0]  = 4'd13;
        r[15:4] = {1'b1, 11'h155};
        for (int i = 0; i < 12; i++) r = put_tr(r, i, 8'(8'h01 + i), 12'h010, 4'd2);
        r = put_tr(r, 12, 8'h62, 12'h7FF, 4'd15);
      end
      12'h7FF: r[15:4] = {1'b1, 11'h3AB};
      12'd1380: r[15:4] = {1'b1, 11'h042};
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [DW_W-1:0] dw_of(input logic [7:0] b);
    logic [DW_W-1:0] w;
    w = {16'hFFFF, {4{8'hFF}}, 1'b0};
    case (b)
      8'h61: w[0] = 1'b1;
      8'h62: begin
        w[0] = 1'b1; w[8:1] = 8'h7A; w[16:9] = 8'h61; w[24:17] = 8'h61; w[32:25] = 8'h01;
      end
      8'h63: begin
        w[8:1] = 8'h62; w[48:33] = {8'h61, 8'h62};
      end
      8'h71: w[0] = 1'b1;
      default: ;
    endcase
    return w;
  endfunction

  assign in_dflt = dw_of(in_byte);
  assign st_rec  = rec_of(req_addr);

  // ---- reference model state and scoreboard queues ----
  logic [11:0] m_cur = 12'd0;
  logic [7:0]  m_p1 = 8'h00, m_p2 = 8'h00;
  int          m_h = 0;
  logic [15:0] exp_q[$];
  string       exp_tag[$];
  logic [10:0] mexp_q[$];
  string       mexp_tag[$];
  logic [11:0] hold_addr = 12'd0;
  logic [3:0]  hold_type = 4'd0;

  task automatic model(input logic [7:0] b, input bit first,
                       output logic [11:0] na, output logic [3:0] nt);
    logic [REC_W-1:0] r;
    logic [DW_W-1:0]  w;
    bit found;
    r = rec_of(m_cur);
    w = dw_of(b);
    found = 1'b0;
    if (first) m_h = 0;
    if (!first) begin
      for (int i = 0; i < int'(r[3:0]); i++) begin
        if (!found && r[16 + 24*i +: 8] == b) begin
          found = 1'b1;
          na = r[16 + 24*i + 8 +: 12];
          nt = r[16 + 24*i + 20 +: 4];
        end
      end
    end
    if (!found && m_h >= 2 && w[48:41] == m_p2 && w[40:33] == m_p1) begin
      found = 1'b1; na = 12'(1281 + int'(b)); nt = 4'd1;
    end
    if (!found && m_h >= 1) begin
      for (int k = 0; k < 4; k++) begin
        if (!found && w[1 + 8*k +: 8] == m_p1) begin
          found = 1'b1; na = 12'(257 + 4*int'(b) + k); nt = 4'd1;
        end
      end
    end
    if (!found && w[0]) begin
      found = 1'b1; na = 12'(1 + int'(b)); nt = 4'd1;
    end
    if (!found) begin
      na = 12'd0; nt = 4'd0;
    end
    m_p2 = m_p1;
    m_p1 = b;
    if (m_h < 2) m_h = m_h + 1;
    m_cur = na;
  endtask

  task automatic send(input logic [7:0] b, input bit first, input string tag);
    logic [11:0]      na;
    logic [3:0]       nt;
    logic [REC_W-1:0] r;
    @(negedge clk);
    in_valid = 1'b1;
    in_first = first;
    in_byte  = b;
    model(b, first, na, nt);
    exp_q.push_back({nt, na});
    exp_tag.push_back(tag);
    r = rec_of(na);
    if (r[15]) begin
      mexp_q.push_back(r[14:4]);
      mexp_tag.push_back({tag, "/R10"});
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
    end
  endtask

  // ---- monitor ----
  initial begin
    logic [15:0] e;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !done) begin
        if (req_valid) begin
          n_tests++;
          if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R1: unexpected request %0h, expected none", req_addr);
          end else begin
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            if ({req_type, req_addr} !== e) begin
              n_fail++;
              $display("FAIL %s: req %0h type %0h, expected %0h type %0h",
                       t, req_addr, req_type, e[11:0], e[15:12]);
            end
            hold_addr = e[11:0];
            hold_type = e[15:12];
          end
        end else begin
          n_tests++;
          if (req_addr !== hold_addr || req_type !== hold_type) begin
            n_fail++;
            $display("FAIL R11: idle req %0h type %0h, expected %0h type %0h",
                     req_addr, req_type, hold_addr, hold_type);
          end
        end
        if (match_hit) begin
          n_tests++;
          if (mexp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R10: unexpected match %0h, expected none", match_addr);
          end else begin
            t = mexp_tag.pop_front();
            if (match_addr !== mexp_q[0]) begin
              n_fail++;
              $display("FAIL %s: match %0h, expected %0h", t, match_addr, mexp_q[0]);
            end
            void'(mexp_q.pop_front());
          end
        end
      end
    end
  end

  // ---- watchdog ----
  initial begin
    #(CLK_PER * 5000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---- stimulus ----
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    if (req_valid !== 1'b0 || req_addr !== 12'd0 || req_type !== 4'd0 || match_hit !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: reset state v%0b %0h t%0h m%0b, expected 0 0 0 0",
               req_valid, req_addr, req_type, match_hit);
    end
    // packet: depth-1 start, duplicate triggers, last stored slot, depth-2
    send(8'h61, 1'b1, "R6/R8");
    send(8'h78, 1'b0, "R3");
    send(8'h62, 1'b0, "R2");
    send(8'h63, 1'b0, "R5");
    // record ignored on a first byte (98 would take 'q' if used)
    send(8'h61, 1'b1, "R6");
    send(8'h71, 1'b1, "R8");
    // depth-2 lowest slot, then depth-3 over depth-2
    send(8'h61, 1'b1, "R6");
    send(8'h62, 1'b0, "R5");
    send(8'h63, 1'b0, "R4");
    // gaps: hold the state, then stored beats depth-1
    send(8'h61, 1'b1, "R1");
    idle(3);
    send(8'h71, 1'b0, "R2");
    idle(2);
    // entry past the count is ignored, falls to start
    send(8'h61, 1'b1, "R6");
    send(8'h63, 1'b0, "R7");
    // history restarts with the new packet
    send(8'h61, 1'b1, "R6");
    send(8'h62, 1'b1, "R9");
    send(8'h63, 1'b0, "R9");
    // start state with no defaults
    send(8'h78, 1'b1, "R7");
    idle(6);
    n_tests++;
    if (exp_q.size() != 0 || mexp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d requests and %0d matches left, expected 0 0",
               exp_q.size(), mexp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule